// File: doc/BRIEF.md
# Two-Bank In-Place FFT Address Generator

This block sequences the memory traffic of an in-place radix-2 decimation-in-frequency FFT of N = 2^r points. The data set lives in two two-port banks, M0 and M1, each holding N/2 words, so a butterfly reads one operand from each bank and writes one result to each bank in the same cycle. One butterfly is issued per clock. For every butterfly the block gives the read address in each bank, the twiddle ROM address, and, on the write side, the address in each bank and a swap bit. The swap bit tells the butterfly datapath whether to exchange its two outputs so that each result goes to the bank that frees up the right location.

All addresses come from one butterfly counter B of r−1 bits, its bitwise inverse, and a pass counter. The bank M1 address takes some bits from B and some from its inverse, chosen by a mask that depends on the pass. No rotation logic is needed. The write side is the read side delayed by the butterfly's pipeline latency, so every result lands in the location its operands came from. A start pulse launches a transform. The block stays busy until the last write and then pulses done.

Top module: `fft_addr_gen`

## Requirements
- R1: Once a start is accepted, rd_valid is high on exactly LOG2N·2^(LOG2N−1) consecutive cycles, starting the cycle after the accepting edge. rd_addr_m0 equals the butterfly counter B, which runs 0..2^(LOG2N−1)−1 within each pass. The pass number s runs 0..LOG2N−1 and advances when B wraps. All read-side outputs are 0 while rd_valid is low.
- R2: In pass s, bit i of rd_addr_m1 is the inverse of B[i] when i ≥ (LOG2N−1)−s, and is B[i] otherwise. In pass 0 it therefore equals B, and in the final pass it equals ~B.
- R3: The swap bit of a butterfly in pass s < LOG2N−1 is B[LOG2N−s−2] when s is even and the inverse of that bit when s is odd. In the final pass the swap bit is 1.
- R4: In pass s, tw_addr is (B shifted left by s) truncated to LOG2N−1 bits, and it is 0 in the final pass. With LOG2N = 4 and B = 1, the values are 1, 2, 4 and 0 in passes 0 to 3.
- R5: wr_valid, wr_addr_m0 and wr_addr_m1 equal rd_valid, rd_addr_m0 and rd_addr_m1 of exactly PIPE_LAT cycles earlier. wr_swap carries that butterfly's swap bit. All write-side outputs are 0 while wr_valid is low.
- R6: busy is high from the cycle after the accepting edge through the cycle of the last write. done is high for exactly the following cycle, with busy low. A start seen in the done cycle or later while idle is accepted.
- R7: A start seen while busy is high has no effect: the running sequence continues unchanged.
- R8: While reset is asserted and right after it, busy, done, rd_valid and wr_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to run one transform, sampled while idle |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle pulse after the last write |
| rd_valid | output | 1 | Read addresses and twiddle address are valid |
| rd_addr_m0 | output | LOG2N-1 | Read address for bank M0 |
| rd_addr_m1 | output | LOG2N-1 | Read address for bank M1 |
| tw_addr | output | LOG2N-1 | Twiddle ROM address for the butterfly being read |
| wr_valid | output | 1 | Write addresses and swap bit are valid |
| wr_addr_m0 | output | LOG2N-1 | Write address for bank M0 |
| wr_addr_m1 | output | LOG2N-1 | Write address for bank M1 |
| wr_swap | output | 1 | Exchange the butterfly outputs for this write |

## Verification
The assertions assume start is a clean synchronous level. They assume the reset lasts long enough to clear the write-side delay line, and that PIPE_LAT matches the real butterfly depth, since the write-lag property is checked against that parameter. The stimulus follows this: reset is held for several cycles, and start pulses arrive while idle, in the middle of a run, during the drain, and held high across a done cycle for back-to-back transforms. In every case the reference model's own acceptance rule decides which starts count.

// File: rtl/fft_agen_pkg.sv
// Package: shared types for the two-bank FFT address generator.
// Assumes: nothing beyond standard SystemVerilog.
package fft_agen_pkg;

    // Sequencer phase: waiting, issuing reads, or draining the write pipeline.
    typedef enum logic [1:0] {
        AG_IDLE  = 2'd0,
        AG_RUN   = 2'd1,
        AG_DRAIN = 2'd2
    } ag_phase_t;

endpackage

// File: rtl/agen_seq.sv
// Module: agen_seq
// Runs the butterfly counter and the pass counter for one transform and
// produces busy/done. It accepts start only while idle. After the last read
// it waits in a drain phase until the delayed "last" marker reaches the
// write side.
// Assumes: LOG2N >= 2, and wb_last is high for one cycle per transform.
module agen_seq
    import fft_agen_pkg::*;
#(
    parameter int LOG2N = 4,
    parameter int CW    = LOG2N - 1,
    parameter int PW    = (LOG2N > 2) ? $clog2(LOG2N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wb_last,
    output logic [CW-1:0] cnt_b,
    output logic [PW-1:0] pass,
    output logic          run,
    output logic          rd_last,
    output logic          busy,
    output logic          done
);

    localparam logic [CW-1:0] CMAX      = {CW{1'b1}};
    localparam logic [PW-1:0] LAST_PASS = PW'(LOG2N - 1);

    ag_phase_t phase;

    // Phase, counter and pass register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= AG_IDLE;
            cnt_b <= '0;
            pass  <= '0;
        end else begin
            case (phase)
                AG_IDLE: begin
                    if (start) begin
                        phase <= AG_RUN;
                        cnt_b <= '0;
                        pass  <= '0;
                    end
                end
                AG_RUN: begin
                    if (cnt_b == CMAX) begin
                        cnt_b <= '0;
                        if (pass == LAST_PASS) begin
                            phase <= AG_DRAIN;
                            pass  <= '0;
                        end else begin
                            pass <= pass + 1'b1;
                        end
                    end else begin
                        cnt_b <= cnt_b + 1'b1;
                    end
                end
                AG_DRAIN: begin
                    if (wb_last) phase <= AG_IDLE;
                end
                default: phase <= AG_IDLE;
            endcase
        end
    end

    // Completion pulse, registered one cycle after the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (phase == AG_DRAIN) && wb_last;
    end

    // Status decode from the phase register.
    always_comb begin
        run     = (phase == AG_RUN);
        busy    = (phase != AG_IDLE);
        rd_last = run && (cnt_b == CMAX) && (pass == LAST_PASS);
    end

endmodule

// File: rtl/agen_map.sv
// Module: agen_map
// Purely combinational mapping from (B, pass) to the bank addresses, the
// twiddle address and the output-swap bit. The M1 address picks each bit
// from B or ~B under a mask of the top 'pass' bits. All outputs are 0 when
// en is low.
// Assumes: pass <= CW.
module agen_map #(
    parameter int CW = 3,
    parameter int PW = 2
) (
    input  logic          en,
    input  logic [CW-1:0] cnt_b,
    input  logic [PW-1:0] pass,
    output logic [CW-1:0] m0,
    output logic [CW-1:0] m1,
    output logic [CW-1:0] tw,
    output logic          swap
);

    localparam logic [CW-1:0] ONES   = {CW{1'b1}};
    localparam logic [CW-1:0] TOPBIT = CW'(1) << (CW - 1);
    localparam logic [PW-1:0] LASTP  = PW'(CW);

    logic [CW-1:0] inv_b;
    logic [CW-1:0] inv_sel;
    logic [CW-1:0] mux_b;
    logic [CW-1:0] pick;

    // Inverted counter and the per-pass selection mask.
    always_comb begin
        inv_b   = ~cnt_b;
        inv_sel = ~(ONES >> pass);
        pick    = TOPBIT >> pass;
    end

    // Per-bit 2:1 multiplexers forming the M1 address.
    for (genvar gi = 0; gi < CW; gi++) begin : g_m1mux
        assign mux_b[gi] = inv_sel[gi] ? inv_b[gi] : cnt_b[gi];
    end

    // Output gating, twiddle shift and swap decode.
    always_comb begin
        m0 = en ? cnt_b : '0;
        m1 = en ? mux_b : '0;
        tw = en ? (cnt_b << pass) : '0;
        if (!en)                swap = 1'b0;
        else if (pass == LASTP) swap = 1'b1;
        else                    swap = (|(cnt_b & pick)) ^ pass[0];
    end

endmodule

// File: rtl/agen_delay.sv
// Module: agen_delay
// Fixed-depth register delay line that aligns the write side with the
// butterfly pipeline. All stages clear to zero on reset.
// Assumes: DEPTH >= 1.
module agen_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [DEPTH];

    for (genvar gs = 0; gs < DEPTH; gs++) begin : g_stage
        // One pipeline register per stage.
        always_ff @(posedge clk) begin
            if (!rst_n) stage[gs] <= '0;
            else if (gs == 0) stage[gs] <= din;
            else stage[gs] <= stage[(gs == 0) ? 0 : gs - 1];
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/fft_addr_gen.sv
// Module: fft_addr_gen (top)
// Address generator for an in-place radix-2 FFT over two two-port banks.
// Issues one butterfly per cycle for LOG2N passes. Write-side addresses and
// the swap bit trail the read side by PIPE_LAT cycles.
// Assumes: LOG2N >= 2, PIPE_LAT >= 1, and the butterfly datapath has exactly
// PIPE_LAT cycles from read address to write.
module fft_addr_gen #(
    parameter int LOG2N    = 4,
    parameter int PIPE_LAT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               rd_valid,
    output logic [LOG2N-2:0]   rd_addr_m0,
    output logic [LOG2N-2:0]   rd_addr_m1,
    output logic [LOG2N-2:0]   tw_addr,
    output logic               wr_valid,
    output logic [LOG2N-2:0]   wr_addr_m0,
    output logic [LOG2N-2:0]   wr_addr_m1,
    output logic               wr_swap
);

    localparam int CW = LOG2N - 1;
    localparam int PW = (LOG2N > 2) ? $clog2(LOG2N) : 1;
    localparam int DW = 2 * CW + 3;

    logic [CW-1:0] cnt_b;
    logic [PW-1:0] pass;
    logic          run;
    logic          rd_last;
    logic          swap_rd;
    logic          last_d;
    logic          wb_last;
    logic [DW-1:0] pipe_in;
    logic [DW-1:0] pipe_out;

    agen_seq #(.LOG2N(LOG2N), .CW(CW), .PW(PW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wb_last (wb_last),
        .cnt_b   (cnt_b),
        .pass    (pass),
        .run     (run),
        .rd_last (rd_last),
        .busy    (busy),
        .done    (done)
    );

    agen_map #(.CW(CW), .PW(PW)) u_map (
        .en    (run),
        .cnt_b (cnt_b),
        .pass  (pass),
        .m0    (rd_addr_m0),
        .m1    (rd_addr_m1),
        .tw    (tw_addr),
        .swap  (swap_rd)
    );

    // Bundle the read-side fields that the write side must replay.
    assign rd_valid = run;
    assign pipe_in  = {run, rd_last, swap_rd, rd_addr_m0, rd_addr_m1};

    agen_delay #(.WIDTH(DW), .DEPTH(PIPE_LAT)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pipe_in),
        .dout  (pipe_out)
    );

    // Unpack the delayed fields onto the write-side ports.
    assign {wr_valid, last_d, wr_swap, wr_addr_m0, wr_addr_m1} = pipe_out;
    assign wb_last = wr_valid & last_d;

endmodule

// File: rtl/fft_addr_gen_chk.sv
// Module: fft_addr_gen_chk
// Property checker bound into fft_addr_gen. It watches ports only and keeps
// its own history of rd_valid to check the write-side lag.
// Assumes: the reset lasts at least PIPE_LAT cycles.
module fft_addr_gen_chk #(
    parameter int LOG2N    = 4,
    parameter int PIPE_LAT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             rd_valid,
    input logic [LOG2N-2:0] rd_addr_m0,
    input logic [LOG2N-2:0] rd_addr_m1,
    input logic [LOG2N-2:0] tw_addr,
    input logic             wr_valid,
    input logic [LOG2N-2:0] wr_addr_m0,
    input logic [LOG2N-2:0] wr_addr_m1,
    input logic             wr_swap
);

    localparam int CW = LOG2N - 1;

    logic [PIPE_LAT-1:0] vhist;

    // Independent history of rd_valid for the write-lag check.
    always_ff @(posedge clk) begin
        if (!rst_n) vhist <= '0;
        else        vhist <= (vhist << 1) | PIPE_LAT'(rd_valid);
    end

    a_r1_m0_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid) && rd_addr_m0 != '0)
            |-> rd_addr_m0 == CW'($past(rd_addr_m0) + 1'b1));

    a_r1_rd_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    a_r1_idle_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_addr_m0 == '0 && rd_addr_m1 == '0 && tw_addr == '0));

    a_r3_last_pass_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr_m1 == CW'(~wr_addr_m0)) |-> wr_swap);

    a_r4_last_pass_tw: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_addr_m1 == CW'(~rd_addr_m0)) |-> tw_addr == '0);

    a_r5_wr_lag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid == vhist[PIPE_LAT-1]);

    a_r5_wr_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && start) |=> busy);

endmodule

bind fft_addr_gen fft_addr_gen_chk #(.LOG2N(LOG2N), .PIPE_LAT(PIPE_LAT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .rd_valid   (rd_valid),
    .rd_addr_m0 (rd_addr_m0),
    .rd_addr_m1 (rd_addr_m1),
    .tw_addr    (tw_addr),
    .wr_valid   (wr_valid),
    .wr_addr_m0 (wr_addr_m0),
    .wr_addr_m1 (wr_addr_m1),
    .wr_swap    (wr_swap)
);

// File: tb/fft_addr_gen_bench.sv
// Bench for fft_addr_gen. A behavioural model keeps the cycle offset since the
// accepted start and derives every expected output from it on each clock.
module fft_addr_gen_bench;

    localparam int R     = 4;
    localparam int LAT   = 2;
    localparam int CW    = R - 1;
    localparam int H     = 1 << CW;
    localparam int TOTAL = R * H;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, rd_valid, wr_valid, wr_swap;
    logic [CW-1:0] rd_addr_m0, rd_addr_m1, tw_addr, wr_addr_m0, wr_addr_m1;

    int n_checks = 0;
    int n_fail   = 0;
    int mt       = -1;
    int cyc      = 0;
    bit cmp_on   = 1'b0;

    always #2 clk = ~clk;

    fft_addr_gen #(.LOG2N(R), .PIPE_LAT(LAT)) u_fft_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_addr_m0(rd_addr_m0), .rd_addr_m1(rd_addr_m1),
        .tw_addr(tw_addr), .wr_valid(wr_valid), .wr_addr_m0(wr_addr_m0),
        .wr_addr_m1(wr_addr_m1), .wr_swap(wr_swap)
    );

    function automatic int ref_m1(int b, int s);
        int res = 0;
        for (int k = 0; k < CW; k++) begin
            int bv = (b >> k) & 1;
            if (k >= CW - s) bv = 1 - bv;
            res = res + (bv << k);
        end
        return res;
    endfunction

    function automatic int ref_sw(int b, int s);
        int bv;
        if (s == R - 1) return 1;
        bv = (b >> (R - s - 2)) & 1;
        return (s % 2 == 0) ? bv : 1 - bv;
    endfunction

    function automatic int ref_tw(int b, int s);
        if (s == R - 1) return 0;
        return (b * (1 << s)) % H;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s t=%0d actual=%0d expected=%0d", tag, what, mt, act, exp);
        end
    endtask

    function automatic bit exp_busy();
        return (mt >= 0) && (mt < TOTAL + LAT);
    endfunction

    // Reference model: offset since the accepted start.
    always @(posedge clk) begin
        if (!rst_n) mt <= -1;
        else if (!exp_busy() && start) mt <= 0;
        else if (exp_busy()) mt <= mt + 1;
        else mt <= -1;
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            int rb, rs, wj, wb, ws;
            bit rv, wv;
            rv = (mt >= 0) && (mt < TOTAL);
            wv = (mt >= LAT) && (mt < TOTAL + LAT);
            rb = rv ? mt % H : 0;
            rs = rv ? mt / H : 0;
            wj = mt - LAT;
            wb = wv ? wj % H : 0;
            ws = wv ? wj / H : 0;
            chk("R6", "busy", busy, exp_busy());
            chk("R6", "done", done, (mt == TOTAL + LAT) ? 1 : 0);
            chk("R1", "rd_valid", rd_valid, rv);
            chk("R1", "rd_addr_m0", rd_addr_m0, rb);
            chk("R2", "rd_addr_m1", rd_addr_m1, rv ? ref_m1(rb, rs) : 0);
            chk("R4", "tw_addr", tw_addr, rv ? ref_tw(rb, rs) : 0);
            chk("R5", "wr_valid", wr_valid, wv);
            chk("R5", "wr_addr_m0", wr_addr_m0, wb);
            chk("R5", "wr_addr_m1", wr_addr_m1, wv ? ref_m1(wb, ws) : 0);
            chk("R3", "wr_swap", wr_swap, wv ? ref_sw(wb, ws) : 0);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 5000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic wait_offset(int target);
        while (mt != target) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8: reset state.
        chk("R8", "busy", busy, 0);
        chk("R8", "done", done, 0);
        chk("R8", "rd_valid", rd_valid, 0);
        chk("R8", "wr_valid", wr_valid, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "idle busy", busy, 0);

        // Single start pulse.
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        // R7: start in the middle of the run.
        wait_offset(10);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7", "rd_addr_m0 after ignored start", rd_addr_m0, 11 % H);
        chk("R7", "busy after ignored start", busy, 1);

        // R7: start during the drain.
        wait_offset(TOTAL);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7", "rd_valid during drain", rd_valid, 0);

        wait_offset(TOTAL + LAT);
        repeat (3) @(negedge clk);
        chk("R6", "idle after done", busy, 0);

        // Back-to-back transforms with start held high.
        start = 1'b1;
        repeat (2 * (TOTAL + LAT + 1) + 3) @(negedge clk);
        start = 1'b0;
        while (mt >= 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R6", "final idle", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule